// File: doc/BRIEF.md
# Word Synchronization State Machine with Hysteresis

This block sits after a word aligner and an 8b/10b decoder. It watches the decoded symbols and decides whether the link holds word synchronization. Every clock carries one word of one symbol (10-bit mode) or two symbols (20-bit mode). For each symbol, three flags come in: the alignment pattern was seen, the code is valid, and there was a disparity error.

Lock is declared once enough clean alignment patterns have arrived. After lock, every bad symbol adds to an error count. That count drops by one only after an unbroken run of good symbols. Lock is lost when the count reaches a limit. The three thresholds are configuration inputs and are captured while reset is held.

Top module: `word_sync_fsm`

## Requirements
- R1: While reset is low and on the first cycle after it, `sync_state` is 0 (loss), `sync_ok` is 0 and `err_cnt` is 0.
- R2: The state encoding is 0 = loss, 1 = acquiring, 2 = locked, 3 = locked with errors. From loss or acquiring, clean patterns are counted. The state becomes 2 on the clock where the total reaches `cfg_acq_need`. While the total is above 0 and below that value, the state is 1.
- R3: A bad symbol seen in loss or acquiring clears the pattern total, and the state goes to 0.
- R4: In state 2 or 3, each bad symbol adds one to `err_cnt`, and the state is 3 while the count is above zero. In states 0, 1 and 2, `err_cnt` is 0.
- R5: In state 3, a run of `cfg_good_run` good symbols with no bad symbol lowers `err_cnt` by one. Any bad symbol restarts the run, and so does each change of the count.
- R6: When good symbols bring `err_cnt` to 0, the state returns to 2.
- R7: When `err_cnt` would reach `cfg_loss_lim`, the state goes to 0, `err_cnt` goes to 0 and `sync_ok` goes to 0. Relocking then needs a full `cfg_acq_need` patterns.
- R8: When `wide_mode` is 1, both lanes (bit 0 and bit 1 of each flag vector) are evaluated. Two bad symbols in one clock add 2, two patterns count 2, and two good symbols count 2 toward a run. When `wide_mode` is 0, lane 1 is ignored.
- R9: A symbol is bad when its `sym_code_ok` bit is 0 or its `sym_disp_err` bit is 1. A pattern flag on a bad symbol does not count.
- R10: The thresholds (each valid from 1 to 256) are captured only while `rst_n` is low. Changing them later has no effect.
- R11: `sync_ok` is 1 exactly when the state is 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one word per cycle |
| rst_n | input | 1 | Asynchronous active-low reset; thresholds captured while low |
| cfg_acq_need | input | 9 | Patterns needed for lock (1..256) |
| cfg_loss_lim | input | 9 | Error count that drops lock (1..256) |
| cfg_good_run | input | 9 | Good symbols per error decrement (1..256) |
| wide_mode | input | 1 | 1 = two symbols per word, 0 = one |
| sym_pattern | input | 2 | Per-lane alignment pattern seen |
| sym_code_ok | input | 2 | Per-lane valid code |
| sym_disp_err | input | 2 | Per-lane disparity error |
| sync_ok | output | 1 | Lock status |
| sync_state | output | 2 | Current state code |
| err_cnt | output | 9 | Current error count |

## Verification
The vector walk mixes clean patterns, plain good words, invalid codes and disparity errors. These separate counting patterns from resetting on errors. Runs of good symbols are broken by errors at different points, to tell a restarted run from one that kept its progress. Narrow-mode words carry junk on lane 1, and wide-mode words carry double patterns, double errors and mixed lanes, to show how each lane is weighted. Directed tests then use the minimum and maximum thresholds (1 and 256) and change the thresholds without a reset to show they were latched.

// File: rtl/word_sync_fsm.sv
module word_sync_fsm #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_acq_need,
  input  logic [CW-1:0] cfg_loss_lim,
  input  logic [CW-1:0] cfg_good_run,
  input  logic          wide_mode,
  input  logic [1:0]    sym_pattern,
  input  logic [1:0]    sym_code_ok,
  input  logic [1:0]    sym_disp_err,
  output logic          sync_ok,
  output logic [1:0]    sync_state,
  output logic [CW-1:0] err_cnt
);
  localparam int XW = CW + 1;

  typedef enum logic [1:0] {S_LOSS = 2'd0, S_ACQ = 2'd1, S_LOCK = 2'd2, S_ERR = 2'd3} st_t;

  st_t           st;
  logic [CW-1:0] acq_q, loss_q, run_q;
  logic [XW-1:0] acq_cnt, good_cnt, errs;

  logic [1:0] lane_on, bad, good, pat;
  logic [XW-1:0] n_bad, n_good, n_pat;
  logic [XW-1:0] acq_sum, err_sum, good_sum;

  assign lane_on = {wide_mode, 1'b1};
  assign bad     = lane_on & (~sym_code_ok | sym_disp_err);
  assign good    = lane_on & ~bad;
  assign pat     = good & sym_pattern;
  assign n_bad   = XW'(bad[0])  + XW'(bad[1]);
  assign n_good  = XW'(good[0]) + XW'(good[1]);
  assign n_pat   = XW'(pat[0])  + XW'(pat[1]);
  assign acq_sum  = acq_cnt + n_pat;
  assign err_sum  = errs + n_bad;
  assign good_sum = good_cnt + n_good;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acq_q  <= cfg_acq_need;
      loss_q <= cfg_loss_lim;
      run_q  <= cfg_good_run;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_LOSS;
      acq_cnt  <= '0;
      good_cnt <= '0;
      errs     <= '0;
    end else begin
      case (st)
        S_LOSS, S_ACQ: begin
          if (n_bad != 0) begin
            st      <= S_LOSS;
            acq_cnt <= '0;
          end else if (n_pat != 0) begin
            if (acq_sum >= {1'b0, acq_q}) begin
              st      <= S_LOCK;
              acq_cnt <= '0;
            end else begin
              st      <= S_ACQ;
              acq_cnt <= acq_sum;
            end
          end
          good_cnt <= '0;
          errs     <= '0;
        end
        default: begin
          if (n_bad != 0) begin
            good_cnt <= '0;
            if (err_sum >= {1'b0, loss_q}) begin
              st   <= S_LOSS;
              errs <= '0;
            end else begin
              st   <= S_ERR;
              errs <= err_sum;
            end
          end else if (st == S_ERR) begin
            if (good_sum >= {1'b0, run_q}) begin
              good_cnt <= '0;
              errs     <= errs - 1'b1;
              if (errs == XW'(1)) st <= S_LOCK;
            end else begin
              good_cnt <= good_sum;
            end
          end
        end
      endcase
    end
  end

  assign sync_state = st;
  assign sync_ok    = (st == S_LOCK) || (st == S_ERR);
  assign err_cnt    = errs[CW-1:0];
endmodule

module word_sync_fsm_chk #(
  parameter int CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] loss_q,
  input logic          wide_mode,
  input logic [1:0]    sym_code_ok,
  input logic [1:0]    sym_disp_err,
  input logic          sync_ok,
  input logic [1:0]    sync_state,
  input logic [CW-1:0] err_cnt
);
  logic lane0_bad;
  logic any_bad;
  assign lane0_bad = ~sym_code_ok[0] | sym_disp_err[0];
  assign any_bad   = lane0_bad | (wide_mode & (~sym_code_ok[1] | sym_disp_err[1]));

  p_err_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_state != 2'd3) |-> (err_cnt == '0));

  p_err_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_state == 2'd3) |-> (err_cnt != '0));

  p_err_below_lim_r7: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, err_cnt} < {1'b0, loss_q});

  p_drop_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_ok) |-> (sync_state == 2'd0 && err_cnt == '0));

  p_lock_from_acq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_ok) |-> (sync_state == 2'd2 && !$past(any_bad)));

  p_bad_resets_acq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_state == 2'd1 && lane0_bad) |=> (sync_state == 2'd0));

  p_err_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_state == 2'd3 && !any_bad) |=> (err_cnt == $past(err_cnt) || err_cnt == $past(err_cnt) - 1'b1));

  p_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ok == sync_state[1]);
endmodule

bind word_sync_fsm word_sync_fsm_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .loss_q(loss_q), .wide_mode(wide_mode),
  .sym_code_ok(sym_code_ok), .sym_disp_err(sym_disp_err),
  .sync_ok(sync_ok), .sync_state(sync_state), .err_cnt(err_cnt));

// File: tb/test_word_sync_fsm.sv
module test_word_sync_fsm;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] cfg_acq_need = 9'd3, cfg_loss_lim = 9'd3, cfg_good_run = 9'd2;
  logic       wide_mode = 1'b0;
  logic [1:0] sym_pattern = 2'b00, sym_code_ok = 2'b11, sym_disp_err = 2'b00;
  logic       sync_ok;
  logic [1:0] sync_state;
  logic [8:0] err_cnt;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  word_sync_fsm i_word_sync_fsm (
    .clk(clk), .rst_n(rst_n), .cfg_acq_need(cfg_acq_need), .cfg_loss_lim(cfg_loss_lim),
    .cfg_good_run(cfg_good_run), .wide_mode(wide_mode), .sym_pattern(sym_pattern),
    .sym_code_ok(sym_code_ok), .sym_disp_err(sym_disp_err),
    .sync_ok(sync_ok), .sync_state(sync_state), .err_cnt(err_cnt));

  // {wide, pattern[1:0], code_ok[1:0], disp_err[1:0], exp_state[1:0], exp_err[8:0]}
  // thresholds: acquire 3, loss 3, good run 2
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 2'b01, 2'b11, 2'b00, 2'd1, 9'd0}, // R2 first pattern
    {1'b0, 2'b00, 2'b11, 2'b00, 2'd1, 9'd0}, // R2 plain good word holds
    {1'b0, 2'b00, 2'b10, 2'b00, 2'd0, 9'd0}, // R3 bad clears
    {1'b0, 2'b01, 2'b11, 2'b00, 2'd1, 9'd0}, // R2
    {1'b0, 2'b01, 2'b11, 2'b00, 2'd1, 9'd0}, // R2
    {1'b0, 2'b01, 2'b01, 2'b10, 2'd2, 9'd0}, // R2 R8 lane1 junk ignored
    {1'b0, 2'b00, 2'b11, 2'b01, 2'd3, 9'd1}, // R4 R9 disparity
    {1'b0, 2'b00, 2'b11, 2'b00, 2'd3, 9'd1}, // R5
    {1'b0, 2'b00, 2'b10, 2'b00, 2'd3, 9'd2}, // R5 run broken
    {1'b0, 2'b00, 2'b11, 2'b00, 2'd3, 9'd2}, // R5
    {1'b0, 2'b00, 2'b11, 2'b00, 2'd3, 9'd1}, // R5 decrement
    {1'b0, 2'b00, 2'b11, 2'b00, 2'd3, 9'd1}, // R5
    {1'b0, 2'b00, 2'b11, 2'b00, 2'd2, 9'd0}, // R6 back to lock
    {1'b0, 2'b00, 2'b10, 2'b00, 2'd3, 9'd1}, // R4
    {1'b0, 2'b00, 2'b10, 2'b00, 2'd3, 9'd2}, // R4
    {1'b0, 2'b00, 2'b10, 2'b00, 2'd0, 9'd0}, // R7 lose lock
    {1'b0, 2'b01, 2'b10, 2'b00, 2'd0, 9'd0}, // R9 pattern on bad symbol
    {1'b0, 2'b01, 2'b11, 2'b00, 2'd1, 9'd0}, // R7 fresh acquisition
    {1'b1, 2'b11, 2'b11, 2'b00, 2'd2, 9'd0}, // R8 two patterns
    {1'b1, 2'b00, 2'b00, 2'b00, 2'd3, 9'd2}, // R8 two errors
    {1'b1, 2'b00, 2'b11, 2'b00, 2'd3, 9'd1}, // R8 two good symbols
    {1'b1, 2'b00, 2'b11, 2'b00, 2'd2, 9'd0}, // R6 R8
    {1'b1, 2'b00, 2'b11, 2'b10, 2'd3, 9'd1}, // R8 R9 lane1 disparity
    {1'b1, 2'b00, 2'b00, 2'b00, 2'd0, 9'd0}  // R7 R8 limit reached
  };

  task automatic chk(input string req, input logic [1:0] st_e, input logic [8:0] err_e);
    logic sync_e;
    sync_e = st_e[1];
    checks++;
    if (sync_state !== st_e || err_cnt !== err_e || sync_ok !== sync_e) begin
      errors++;
      $display("FAIL %s: state/err/sync = %0d/%0d/%0b, expected %0d/%0d/%0b",
               req, sync_state, err_cnt, sync_ok, st_e, err_e, sync_e);
    end
  endtask

  task automatic step(input logic w, input logic [1:0] p, input logic [1:0] ok, input logic [1:0] d);
    wide_mode = w; sym_pattern = p; sym_code_ok = ok; sym_disp_err = d;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [8:0] a, input logic [8:0] l, input logic [8:0] g);
    cfg_acq_need = a; cfg_loss_lim = l; cfg_good_run = g;
    wide_mode = 1'b0; sym_pattern = 2'b00; sym_code_ok = 2'b11; sym_disp_err = 2'b00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset(9'd3, 9'd3, 9'd2);
    chk("R1 reset", 2'd0, 9'd0);
    step(1'b0, 2'b00, 2'b11, 2'b00);
    chk("R1 idle after reset", 2'd0, 9'd0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][17], VEC[i][16:15], VEC[i][14:13], VEC[i][12:11]);
      chk($sformatf("R2-table vector %0d", i), VEC[i][10:9], VEC[i][8:0]);
    end

    // R10: new thresholds without reset are ignored; acquire still needs 3
    cfg_acq_need = 9'd1; cfg_loss_lim = 9'd1; cfg_good_run = 9'd1;
    step(1'b0, 2'b01, 2'b11, 2'b00);
    chk("R10 acquire threshold latched", 2'd1, 9'd0);
    step(1'b0, 2'b01, 2'b11, 2'b00);
    step(1'b0, 2'b01, 2'b11, 2'b00);
    chk("R10 lock after latched count", 2'd2, 9'd0);
    step(1'b0, 2'b00, 2'b10, 2'b00);
    chk("R10 loss threshold latched", 2'd3, 9'd1);

    // minimum thresholds
    do_reset(9'd1, 9'd1, 9'd1);
    step(1'b0, 2'b01, 2'b11, 2'b00);
    chk("R2 single pattern locks", 2'd2, 9'd0);
    step(1'b0, 2'b00, 2'b11, 2'b01);
    chk("R7 single error drops lock", 2'd0, 9'd0);

    // maximum thresholds
    do_reset(9'd256, 9'd2, 9'd256);
    for (int i = 0; i < 255; i++) step(1'b0, 2'b01, 2'b11, 2'b00);
    chk("R2 255 of 256 patterns", 2'd1, 9'd0);
    step(1'b0, 2'b01, 2'b11, 2'b00);
    chk("R2 256th pattern locks", 2'd2, 9'd0);
    step(1'b0, 2'b00, 2'b10, 2'b00);
    chk("R4 error in lock", 2'd3, 9'd1);
    for (int i = 0; i < 255; i++) step(1'b0, 2'b00, 2'b11, 2'b00);
    chk("R5 255 of 256 good", 2'd3, 9'd1);
    step(1'b0, 2'b00, 2'b11, 2'b00);
    chk("R6 256th good relocks", 2'd2, 9'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule